// File: doc/BRIEF.md
# Receive Dword-to-Qword Payload Aligner

This block sits on the receive side of a PCI Express transaction layer. Packets arrive one 32-bit dword per cycle, marked with start and end of packet. They leave on a 64-bit bus with valid/ready handshaking. Header dwords are packed two per beat, low half first, and keep their wire byte order. Payload dwords are byte-reversed, so the first payload byte of each dword sits in its least significant byte.

The block decodes the format and type fields of header dword 0. From them it learns the header length, whether the packet carries data, and whether it is a completion. It then decides whether a pad dword must separate the last header dword from the first payload dword. The pad makes the payload land on the 64-bit lane its address implies: address bit 2 set means the high half.

For requests, address bit 2 is read from the last header dword. For completions it is read from the lower-address field. Completions that answer configuration or I/O reads are always placed as qword aligned. The requester reserves a tag range for those reads, and the block recognises such completions by that range. A two-bit qualifier marks which halves of each beat hold a real dword.

Top module: `tlp_qw_align`

## Requirements
- R1: Header dwords leave in arrival order, the first on bits [31:0] of the first beat, with their byte order unchanged.
- R2: Every payload dword is byte-reversed: input bits [31:24] go to output bits [7:0], and so on.
- R3: For a 3-dword header with address bit 2 (header dword 2, bit 2) equal to 1, the first payload dword appears on bits [63:32] of the beat that carries header dword 2.
- R4: For a 3-dword header with address bit 2 equal to 0, a pad slot fills bits [63:32] after header dword 2, and the payload starts on bits [31:0] of the next beat.
- R5: For a 4-dword header with address bit 2 (header dword 3, bit 2) equal to 0, the payload starts on bits [31:0] of the third beat.
- R6: For a 4-dword header with address bit 2 equal to 1, a pad slot fills bits [31:0] of the third beat, and the payload starts on bits [63:32].
- R7: A completion is a packet whose type field (dword 0 bits [28:25]) is 4'b0101. A completion with data takes its placement bit from bit 2 of its lower-address field (dword 2 bits [6:0]). If its tag (dword 2 bits [15:8]) is at or above CFGIO_TAG_MIN, that bit is taken as 0.
- R8: The format field is dword 0 bits [30:29]: bit 29 set means a 4-dword header, bit 30 set means data. A packet without data yields only its header. With an odd header length, the final beat has only its low half valid.
- R9: out_dv_o[0] flags bits [31:0] and out_dv_o[1] flags bits [63:32]. Each flag is 1 exactly when that half carries a header or payload dword, and 0 for a pad or an unused half.
- R10: out_sop_o is 1 on the first beat of a packet, and out_eop_o is 1 on the beat holding its last dword.
- R11: While out_valid_o is 1 and out_ready_i is 0, the output beat and its flags stay unchanged and in_ready_o is 0.
- R12: After reset, out_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input dword valid |
| in_ready_o | output | 1 | Input dword accepted when high with valid |
| in_dw_i | input | 32 | Input dword, wire byte order |
| in_sop_i | input | 1 | Input dword is first of packet |
| in_eop_i | input | 1 | Input dword is last of packet |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream accepts the beat |
| out_data_o | output | 64 | Output beat, low half first |
| out_dv_o | output | 2 | Per-half dword-valid qualifier |
| out_sop_o | output | 1 | First beat of packet |
| out_eop_o | output | 1 | Last beat of packet |

## Verification
The assertions assume that packets are well formed. Every packet opens with sop and closes with eop. No packet that carries data ends inside its header. A packet with data has at least one payload dword. The stimulus only builds packets from a complete header plus one to eight payload dwords, and completions only ever get 3-dword headers. Random gaps on the input and random backpressure on the output exercise the hold behaviour. Tags are drawn both inside and outside the reserved range.

// File: rtl/tlp_qw_pkg.sv
package tlp_qw_pkg;
  localparam int unsigned DW_W      = 32;
  localparam int unsigned BEAT_W    = 2 * DW_W;
  localparam int unsigned FMT4_BIT  = 29;
  localparam int unsigned FMTD_BIT  = 30;
  localparam int unsigned TYPE_HI   = 28;
  localparam int unsigned TYPE_LO   = 25;
  localparam logic [3:0]  CPL_TYPE  = 4'b0101;
  localparam int unsigned TAG_LO    = 8;
  localparam int unsigned A2_BIT    = 2;
  localparam int unsigned IDX_W     = 3;
  localparam logic [IDX_W-1:0] IDX_SAT = 3'd4;

  typedef struct packed {
    logic [BEAT_W-1:0] data;
    logic [1:0]        dv;
    logic              sop;
    logic              eop;
  } beat_t;
endpackage

// File: rtl/tlp_dw_bswap.sv
module tlp_dw_bswap #(
  parameter int unsigned BYTES = 4
) (
  input  logic [8*BYTES-1:0] dw_i,
  output logic [8*BYTES-1:0] dw_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign dw_o[8*b +: 8] = dw_i[8*(BYTES-1-b) +: 8];
  end
endmodule

// File: rtl/tlp_hdr_track.sv
module tlp_hdr_track
  import tlp_qw_pkg::*;
#(
  parameter int unsigned TAG_W         = 8,
  parameter logic [TAG_W-1:0] CFGIO_TAG_MIN = 8'hF0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acc_i,
  input  logic [DW_W-1:0] dw_i,
  input  logic            sop_i,
  input  logic            eop_i,
  output logic            is_hdr_o,
  output logic            pad_after_o
);
  logic [IDX_W-1:0] idx_q, idx;
  logic             fmt4_q, data_q, cpl_q;
  logic             fmt4, data, cpl;
  logic [IDX_W-1:0] last_idx;
  logic             at_last, cfgio, a2;
  logic [TAG_W-1:0] tag;

  assign idx  = sop_i ? '0 : idx_q;
  assign fmt4 = (idx == '0) ? dw_i[FMT4_BIT] : fmt4_q;
  assign data = (idx == '0) ? dw_i[FMTD_BIT] : data_q;
  assign cpl  = (idx == '0) ? (dw_i[TYPE_HI:TYPE_LO] == CPL_TYPE) : cpl_q;

  assign last_idx = fmt4 ? IDX_W'(3) : IDX_W'(2);
  assign is_hdr_o = (idx <= last_idx);
  assign at_last  = (idx == last_idx);

  // placement bit lives in the last header dword for every header shape
  assign tag   = dw_i[TAG_LO +: TAG_W];
  assign cfgio = cpl && !fmt4 && (tag >= CFGIO_TAG_MIN);
  assign a2    = cfgio ? 1'b0 : dw_i[A2_BIT];
  // pad needed when the lane after the header differs from the address lane
  assign pad_after_o = at_last && data && (fmt4 ? a2 : !a2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      fmt4_q <= 1'b0;
      data_q <= 1'b0;
      cpl_q  <= 1'b0;
    end else if (acc_i) begin
      if (eop_i)              idx_q <= '0;
      else if (idx != IDX_SAT) idx_q <= idx + 1'b1;
      else                     idx_q <= idx;
      if (idx == '0) begin
        fmt4_q <= fmt4;
        data_q <= data;
        cpl_q  <= cpl;
      end
    end
  end

  // a pad is only ever requested ahead of payload, so the packet cannot end there
  assert_pad_not_eop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && pad_after_o |-> !eop_i);
  // packet boundary restarts the header count
  assert_idx_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && eop_i |=> idx_q == '0);
endmodule

// File: rtl/tlp_qw_packer.sv
module tlp_qw_packer
  import tlp_qw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_valid_i,
  output logic              slot_ready_o,
  input  logic [DW_W-1:0]   slot_dw_i,
  input  logic              slot_sop_i,
  input  logic              slot_eop_i,
  input  logic              slot_pad_after_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BEAT_W-1:0] out_data_o,
  output logic [1:0]        out_dv_o,
  output logic              out_sop_o,
  output logic              out_eop_o
);
  logic            lane_q;
  logic [DW_W-1:0] lo_dw_q;
  logic            lo_dv_q, lo_sop_q;
  logic            out_valid_q;
  beat_t           out_q, beat;
  logic            acc, emit;

  assign slot_ready_o = !out_valid_q || out_ready_i;
  assign acc          = slot_valid_i && slot_ready_o;
  assign emit         = acc && (lane_q || slot_pad_after_i || slot_eop_i);

  always_comb begin
    if (lane_q) begin
      beat.data = {slot_dw_i, lo_dw_q};
      beat.dv   = {1'b1, lo_dv_q};
      beat.sop  = lo_sop_q;
    end else begin
      beat.data = {{DW_W{1'b0}}, slot_dw_i};
      beat.dv   = 2'b01;
      beat.sop  = slot_sop_i;
    end
    beat.eop = slot_eop_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q   <= 1'b0;
      lo_dw_q  <= '0;
      lo_dv_q  <= 1'b0;
      lo_sop_q <= 1'b0;
    end else if (acc) begin
      if (!lane_q) begin
        if (!slot_pad_after_i && !slot_eop_i) begin
          lo_dw_q  <= slot_dw_i;
          lo_dv_q  <= 1'b1;
          lo_sop_q <= slot_sop_i;
          lane_q   <= 1'b1;
        end
      end else if (slot_pad_after_i) begin
        // next beat opens with a pad in the low half
        lo_dw_q  <= '0;
        lo_dv_q  <= 1'b0;
        lo_sop_q <= 1'b0;
        lane_q   <= 1'b1;
      end else begin
        lane_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_q       <= '0;
    end else if (emit) begin
      out_valid_q <= 1'b1;
      out_q       <= beat;
    end else if (out_ready_i) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_q.data;
  assign out_dv_o    = out_q.dv;
  assign out_sop_o   = out_q.sop;
  assign out_eop_o   = out_q.eop;

  assert_hold_beat_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_dv_o)
      && $stable(out_sop_o) && $stable(out_eop_o));
  assert_no_accept_stalled_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !slot_ready_o);
  assert_dv_nonzero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_dv_o != 2'b00);
  assert_sop_low_lane_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_sop_o |-> out_dv_o[0]);
  assert_lane_reset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && slot_eop_i |=> !lane_q);
endmodule

// File: rtl/tlp_qw_align.sv
module tlp_qw_align
  import tlp_qw_pkg::*;
#(
  parameter int unsigned TAG_W         = 8,
  parameter logic [TAG_W-1:0] CFGIO_TAG_MIN = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DW_W-1:0]   in_dw_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BEAT_W-1:0] out_data_o,
  output logic [1:0]        out_dv_o,
  output logic              out_sop_o,
  output logic              out_eop_o
);
  localparam int unsigned DW_BYTES = DW_W / 8;

  logic            is_hdr, pad_after, acc;
  logic [DW_W-1:0] dw_swapped, slot_dw;

  assign acc = in_valid_i && in_ready_o;

  tlp_hdr_track #(
    .TAG_W(TAG_W),
    .CFGIO_TAG_MIN(CFGIO_TAG_MIN)
  ) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .dw_i       (in_dw_i),
    .sop_i      (in_sop_i),
    .eop_i      (in_eop_i),
    .is_hdr_o   (is_hdr),
    .pad_after_o(pad_after)
  );

  tlp_dw_bswap #(.BYTES(DW_BYTES)) u_swap (
    .dw_i(in_dw_i),
    .dw_o(dw_swapped)
  );

  assign slot_dw = is_hdr ? in_dw_i : dw_swapped;

  tlp_qw_packer u_pack (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .slot_valid_i    (in_valid_i),
    .slot_ready_o    (in_ready_o),
    .slot_dw_i       (slot_dw),
    .slot_sop_i      (in_sop_i),
    .slot_eop_i      (in_eop_i),
    .slot_pad_after_i(pad_after),
    .out_valid_o     (out_valid_o),
    .out_ready_i     (out_ready_i),
    .out_data_o      (out_data_o),
    .out_dv_o        (out_dv_o),
    .out_sop_o       (out_sop_o),
    .out_eop_o       (out_eop_o)
  );
endmodule

// File: tb/tb_tlp_qw_align.sv
module tb_tlp_qw_align;
  localparam logic [7:0] TAG_MIN = 8'hF0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_dw_i = '0;
  logic        in_sop_i = 1'b0;
  logic        in_eop_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [63:0] out_data_o;
  logic [1:0]  out_dv_o;
  logic        out_sop_o, out_eop_o;

  always #5 clk_i = ~clk_i;

  tlp_qw_align #(.CFGIO_TAG_MIN(TAG_MIN)) dut (.*);

  typedef struct {
    logic [63:0] d;
    logic [1:0]  dv;
    logic        sop;
    logic        eop;
    string       tag;
  } beat_t;

  beat_t       exp_q[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  int          rdy_mode = 0;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;
  bit          stall_prev = 1'b0;
  logic [67:0] stall_snap;

  function automatic logic [31:0] bsw(logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit plain(string t);
    return (t == "R1") || (t == "R2");
  endfunction

  // output monitor: set ready at falling edge, compare accepted beats after it settles
  always @(negedge clk_i) begin
    if (mon_on) begin
      case (rdy_mode)
        0: out_ready_i = 1'b1;
        1: out_ready_i = ($urandom_range(0, 9) < 7);
        default: out_ready_i = 1'b0;
      endcase
      #1;
      if (stall_prev) begin
        chk("R11 held beat", {out_valid_o, out_data_o, out_dv_o, out_sop_o, out_eop_o},
            {1'b1, stall_snap[67:4], stall_snap[3:0]});
      end
      stall_prev = out_valid_o && !out_ready_i;
      if (stall_prev) begin
        stall_snap = {out_data_o, out_dv_o, out_sop_o, out_eop_o};
        chk("R11 in_ready low", {63'd0, in_ready_o}, 64'd0);
      end
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) begin
          chk("R10 unexpected beat", 64'd1, 64'd0);
        end else begin
          beat_t e;
          logic [63:0] m;
          e = exp_q.pop_front();
          m = {{32{e.dv[1]}}, {32{e.dv[0]}}};
          chk(e.tag, out_data_o & m, e.d & m);
          chk("R9 dv", {62'd0, out_dv_o}, {62'd0, e.dv});
          chk("R10 sop/eop", {62'd0, out_sop_o, out_eop_o}, {62'd0, e.sop, e.eop});
        end
      end
    end
  end

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic push(logic [31:0] d, logic s, logic e);
    bit acc;
    in_valid_i = 1'b1; in_dw_i = d; in_sop_i = s; in_eop_i = e;
    forever begin
      #2;
      acc = in_ready_o;
      @(negedge clk_i);
      if (acc) break;
    end
    in_valid_i = 1'b0;
    if (rdy_mode == 1 && $urandom_range(0, 3) == 0) @(negedge clk_i);
  endtask

  task automatic send_pkt(bit fmt4, bit has_data, bit cpl, logic [31:0] dw2,
                          logic [31:0] dw3, int nd);
    logic [31:0] pkt[$];
    logic [31:0] sd[$];
    bit          sv[$];
    string       st[$];
    logic [4:0]  typ;
    bit          a2, pad;
    string       ftag;
    typ = cpl ? 5'b01010 : ($urandom_range(0, 1) ? 5'b00000 : 5'b00100);
    pkt.push_back({1'b0, has_data, fmt4, typ, 24'($urandom)});
    pkt.push_back($urandom);
    pkt.push_back(dw2);
    if (fmt4) pkt.push_back(dw3);
    foreach (pkt[i]) begin
      sd.push_back(pkt[i]); sv.push_back(1'b1);
      st.push_back((!has_data && i == pkt.size() - 1) ? "R8" : "R1");
    end
    if (has_data) begin
      a2 = fmt4 ? dw3[2] : dw2[2];
      if (cpl && dw2[15:8] >= TAG_MIN) a2 = 1'b0;
      pad = fmt4 ? a2 : !a2;
      ftag = cpl ? "R7" : (fmt4 ? (a2 ? "R6" : "R5") : (a2 ? "R3" : "R4"));
      if (pad) begin sd.push_back('0); sv.push_back(1'b0); st.push_back(ftag); end
      for (int k = 0; k < nd; k++) begin
        logic [31:0] p;
        p = $urandom;
        pkt.push_back(p);
        sd.push_back(bsw(p)); sv.push_back(1'b1);
        st.push_back(k == 0 ? ftag : "R2");
      end
    end
    for (int i = 0; i < sd.size(); i += 2) begin
      beat_t b;
      string th;
      bit hv;
      hv = (i + 1 < sd.size()) ? sv[i+1] : 1'b0;
      th = (i + 1 < sd.size()) ? st[i+1] : "R1";
      b.d   = {(i + 1 < sd.size()) ? sd[i+1] : 32'd0, sd[i]};
      b.dv  = {hv, sv[i]};
      b.sop = (i == 0);
      b.eop = (i + 2 >= sd.size());
      if (!plain(th))         b.tag = th;
      else if (!plain(st[i])) b.tag = st[i];
      else if (th == "R2" || st[i] == "R2") b.tag = "R2";
      else                    b.tag = "R1";
      exp_q.push_back(b);
    end
    foreach (pkt[i]) push(pkt[i], i == 0, i == pkt.size() - 1);
  endtask

  function automatic logic [31:0] cpl_dw2(logic [7:0] tag, bit a2);
    return {16'($urandom), tag, 1'b0, 4'($urandom), a2, 2'b00};
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #23;
    chk("R12 out_valid after reset", {63'd0, out_valid_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R12 idle after release", {63'd0, out_valid_o}, 64'd0);
    mon_on = 1'b1;
    @(negedge clk_i);
    // directed layouts
    send_pkt(0, 1, 0, 32'h1000_0004, '0, 3);            // R3
    send_pkt(0, 1, 0, 32'h2000_0008, '0, 2);            // R4
    send_pkt(1, 1, 0, 32'h0000_0001, 32'h3000_0010, 4); // R5
    send_pkt(1, 1, 0, 32'h0000_0002, 32'h3000_0014, 1); // R6
    send_pkt(0, 1, 1, cpl_dw2(8'h12, 1'b1), '0, 2);     // R7 plain completion
    send_pkt(0, 1, 1, cpl_dw2(8'hF3, 1'b1), '0, 2);     // R7 reserved tag forced aligned
    send_pkt(0, 0, 0, 32'h4000_0004, '0, 0);            // R8 3-dword, no data
    send_pkt(1, 0, 0, 32'h0, 32'h5000_0000, 0);         // R8 4-dword, no data
    // stall: R11 hold under full backpressure
    rdy_mode = 2;
    fork
      send_pkt(0, 1, 0, 32'h6000_0000, '0, 3);
      begin repeat (8) @(negedge clk_i); rdy_mode = 0; end
    join
    rdy_mode = 1;
    for (int n = 0; n < 300; n++) begin
      int   kind;
      bit   f4, hd, cp;
      logic [7:0] tg;
      kind = $urandom_range(0, 5);
      f4 = (kind == 1) || (kind == 4);
      hd = (kind <= 2);
      cp = (kind == 2) || (kind == 5);
      tg = $urandom_range(0, 1) ? 8'($urandom_range(240, 255)) : 8'($urandom_range(0, 239));
      send_pkt(f4, hd, cp, cp ? cpl_dw2(tg, 1'($urandom)) : $urandom, $urandom,
               $urandom_range(1, 8));
    end
    rdy_mode = 0;
    repeat (40) @(negedge clk_i);
    chk("R10 all beats delivered", 64'(exp_q.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule